// File: doc/BRIEF.md
# Tone Detect Guard Timer

This block sits behind a dual-tone detector front end and turns its raw, per-sample decision into two qualified, active-low indications. Every clock the front end presents a flag saying a valid tone pair is present, together with the 4-bit code of that pair. The block passes the flag straight through as an unguarded tone-detect line. It also drives a data-valid line that only asserts once the tone has persisted for a selectable on-time, and only releases once the tone has been gone for a selectable off-time. Each time data-valid qualifies, the code is captured and held for a status register to read.

A 2-bit guard setting picks the on/off pair: 1 → 20/20 ms, 2 → 30/30 ms, 3 → 40/20 ms. The reserved value 0 acts like 1. A millisecond base is divided from the system clock. When the digit changes without a silent gap, the tone-detect line gives a 2 ms high pulse. Data-valid then releases and requalifies over the on-time before the new code is captured. The block only works while the 3-bit mode input selects receive (value 0). In every other mode it idles.

Top module: `tone_guard_timer`

## Requirements
- R1: In receive mode, td_n_o is low in the cycle after a clock edge that samples tone_vld_i high, and high in the cycle after an edge that samples it low. The guard setting has no effect on this.
- R2: A change of tone_code_i while tone_vld_i stays high drives td_n_o high for PULSE_MS·CLK_PER_MS cycles. td_n_o then returns low if the tone is still present.
- R3: dv_n_o goes low only after tone_vld_i has been high with an unchanged code for the on-time: 20 ms for guard 1, 30 ms for guard 2, 40 ms for guard 3.
- R4: Once low, dv_n_o returns high only after tone_vld_i has been low for the whole off-time: 20 ms for guard 1, 30 ms for guard 2, 20 ms for guard 3.
- R5: Guard setting 0 gives the same on and off times as guard setting 1.
- R6: A gap shorter than the off-time, followed by the same code, leaves dv_n_o low and code_o unchanged. The off-time count restarts with the next absence.
- R7: After a gapless change to a different code, dv_n_o goes high within two cycles. It goes low again after a fresh on-time, and code_o then shows the new code.
- R8: code_o changes only when dv_n_o qualifies. It shows the code that was present at that moment.
- R9: When mode_i is not 0, td_n_o and dv_n_o are high from the next cycle on. After a return to mode 0 with a tone present, qualification restarts from zero.
- R10: After reset, td_n_o and dv_n_o are high and code_o is 0.
- R11: A tone that lasts less than the on-time never drives dv_n_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Function mode; 0 selects receive |
| guard_i | input | 2 | Guard time selection |
| tone_vld_i | input | 1 | Raw valid-tone-pair flag from the detector |
| tone_code_i | input | 4 | Raw decoded digit code |
| td_n_o | output | 1 | Unguarded tone detect, active low |
| dv_n_o | output | 1 | Guard-qualified data valid, active low |
| code_o | output | 4 | Last qualified digit code |

## Verification
A gapless digit change makes two things happen on one clock edge: the tone-detect release pulse starts, and data-valid drops out of its held state. The bench provokes this by switching the code of a qualified digit on a single falling edge, with no gap. It then checks that both lines are high at once, that the pulse ends after exactly its width while data-valid stays high, and that the old code is held until the new digit has served a full on-time. The second case is a short gap that ends inside the off window just as the counter nears expiry. It is judged by data-valid and the code staying unchanged.

// File: rtl/tone_guard_timer.sv
module tone_guard_timer #(
  parameter int CLK_PER_MS = 1000,
  parameter int SHORT_MS   = 20,
  parameter int MID_MS     = 30,
  parameter int LONG_MS    = 40,
  parameter int PULSE_MS   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic [1:0] guard_i,
  input  logic       tone_vld_i,
  input  logic [3:0] tone_code_i,
  output logic       td_n_o,
  output logic       dv_n_o,
  output logic [3:0] code_o
);

  localparam int PW  = $clog2(CLK_PER_MS + 1);
  localparam int MW  = $clog2(LONG_MS + 2);
  localparam int PC  = PULSE_MS * CLK_PER_MS;
  localparam int PCW = $clog2(PC + 1);
  localparam logic [MW-1:0] MS_MAX = {MW{1'b1}};

  typedef enum logic [1:0] {IDLE, ON_WAIT, HELD, OFF_WAIT} st_t;

  st_t           st;
  logic          prev_vld;
  logic [3:0]    prev_code;
  logic [PW-1:0] presc;
  logic [MW-1:0] ms_cnt;
  logic [PCW-1:0] pls_cnt;
  logic          td_q;

  wire active  = (mode_i == 3'd0);
  wire chg     = tone_vld_i && prev_vld && (tone_code_i != prev_code);
  wire event_s = (tone_vld_i != prev_vld) || chg;
  wire restart = !active || event_s || (st == IDLE);
  wire tick    = (presc == PW'(CLK_PER_MS - 1));

  logic [MW-1:0] on_ms, off_ms;
  always_comb begin
    case (guard_i)
      2'd2:    begin on_ms = MW'(MID_MS);   off_ms = MW'(MID_MS);   end
      2'd3:    begin on_ms = MW'(LONG_MS);  off_ms = MW'(SHORT_MS); end
      default: begin on_ms = MW'(SHORT_MS); off_ms = MW'(SHORT_MS); end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld  <= 1'b0;
      prev_code <= 4'd0;
    end else begin
      prev_vld  <= tone_vld_i;
      prev_code <= tone_code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc  <= '0;
      ms_cnt <= '0;
    end else if (restart) begin
      presc  <= '0;
      ms_cnt <= '0;
    end else if (tick) begin
      presc  <= '0;
      if (ms_cnt != MS_MAX) ms_cnt <= ms_cnt + 1'b1;
    end else begin
      presc  <= presc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      code_o <= 4'd0;
    end else if (!active) begin
      st <= IDLE;
    end else begin
      case (st)
        IDLE:     if (tone_vld_i) st <= ON_WAIT;
        ON_WAIT:  if (!tone_vld_i) st <= IDLE;
                  else if (!chg && ms_cnt == on_ms) begin
                    st     <= HELD;
                    code_o <= tone_code_i;
                  end
        HELD:     if (!tone_vld_i) st <= OFF_WAIT;
                  else if (tone_code_i != code_o) st <= ON_WAIT;
        OFF_WAIT: if (tone_vld_i) st <= (tone_code_i == code_o) ? HELD : ON_WAIT;
                  else if (ms_cnt == off_ms) st <= IDLE;
        default:  st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pls_cnt <= '0;
      td_q    <= 1'b1;
    end else begin
      if (!active || !tone_vld_i) pls_cnt <= '0;
      else if (chg)               pls_cnt <= PCW'(PC);
      else if (pls_cnt != 0)      pls_cnt <= pls_cnt - 1'b1;
      td_q <= !(active && tone_vld_i) || chg || (pls_cnt > 1);
    end
  end

  assign td_n_o = td_q;
  assign dv_n_o = !(st == HELD || st == OFF_WAIT);

  assert_idle_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 3'd0) |=> (td_n_o && dv_n_o));

  assert_td_needs_tone_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !td_n_o |-> $past(tone_vld_i));

  assert_dv_fall_with_tone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dv_n_o) |-> $past(tone_vld_i));

  assert_code_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$fell(dv_n_o) && !(dv_n_o && !$past(dv_n_o))) |-> $stable(code_o));

  assert_change_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tone_vld_i && prev_vld && tone_code_i != prev_code) |=> td_n_o);

endmodule

// File: tb/tone_guard_timer_bench.sv
module tone_guard_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPM = 10;
  localparam int PULSE = 2 * CPM;

  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 0;
  logic [1:0] guard = 1;
  logic vld = 0;
  logic [3:0] code = 0;
  wire td_n, dv_n;
  wire [3:0] code_o;

  int checks = 0, fails = 0;

  tone_guard_timer #(.CLK_PER_MS(CPM)) u_tone_guard_timer (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .guard_i(guard),
    .tone_vld_i(vld), .tone_code_i(code),
    .td_n_o(td_n), .dv_n_o(dv_n), .code_o(code_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int on_ms(input logic [1:0] g);
    return (g == 2) ? 30 : (g == 3) ? 40 : 20;
  endfunction
  function automatic int off_ms(input logic [1:0] g);
    return (g == 2) ? 30 : 20;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic v, input logic [3:0] c);
    @(negedge clk);
    vld = v; code = c;
  endtask

  task automatic qualify(input logic [3:0] c, input string req);
    int n = on_ms(guard) * CPM;
    drive(1, c);
    cyc(1);
    chk(td_n == 0, "R1 td low on tone", td_n, 0);
    cyc(n - 3);
    chk(dv_n == 1, {req, " dv high before on-time"}, dv_n, 1);
    cyc(6);
    chk(dv_n == 0, {req, " dv low after on-time"}, dv_n, 0);
    chk(code_o == c, "R8 code latched", code_o, c);
  endtask

  task automatic release_tone(input string req);
    int n = off_ms(guard) * CPM;
    logic [3:0] held = code_o;
    drive(0, code);
    cyc(1);
    chk(td_n == 1, "R1 td high on release", td_n, 1);
    cyc(n - 3);
    chk(dv_n == 0, {req, " dv low before off-time"}, dv_n, 0);
    cyc(6);
    chk(dv_n == 1, {req, " dv high after off-time"}, dv_n, 1);
    chk(code_o == held, "R8 code held on release", code_o, held);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    cyc(3);
    chk(td_n == 1 && dv_n == 1, "R10 reset outputs", {td_n, dv_n}, 3);
    chk(code_o == 0, "R10 reset code", code_o, 0);
    rst_n = 1;
    cyc(2);

    foreach (guard_list[i]) begin end

    for (int g = 1; g < 4; g++) begin
      guard = g[1:0];
      qualify(4'h5, "R3");
      release_tone("R4");
    end

    guard = 0;
    qualify(4'h9, "R5");
    release_tone("R5");

    guard = 3;
    drive(1, 4'h2);
    cyc(on_ms(3) * CPM - 5);
    drive(0, 4'h2);
    cyc(3);
    chk(dv_n == 1, "R11 short tone no dv", dv_n, 1);
    cyc(30 * CPM);
    chk(dv_n == 1, "R11 short tone stays idle", dv_n, 1);

    guard = 1;
    qualify(4'h7, "R3");
    drive(0, 4'h7);
    cyc(off_ms(1) * CPM - 4);
    drive(1, 4'h7);
    cyc(2);
    chk(dv_n == 0, "R6 short gap keeps dv", dv_n, 0);
    chk(code_o == 4'h7, "R6 short gap keeps code", code_o, 7);
    drive(0, 4'h7);
    cyc(off_ms(1) * CPM - 4);
    chk(dv_n == 0, "R6 off count restarted", dv_n, 0);
    drive(1, 4'h7);
    cyc(2);

    drive(1, 4'hC);
    cyc(1);
    chk(td_n == 1, "R2 pulse start", td_n, 1);
    chk(dv_n == 1, "R7 dv released on change", dv_n, 1);
    cyc(PULSE - 3);
    chk(td_n == 1, "R2 pulse still high", td_n, 1);
    cyc(4);
    chk(td_n == 0, "R2 pulse ended", td_n, 0);
    chk(code_o == 4'h7, "R7 old code during requal", code_o, 7);
    cyc(on_ms(1) * CPM - PULSE - 5);
    chk(dv_n == 1, "R7 dv high before requal", dv_n, 1);
    cyc(6);
    chk(dv_n == 0, "R7 dv requalified", dv_n, 0);
    chk(code_o == 4'hC, "R7 new code", code_o, 12);

    drive(1, 4'hC);
    mode = 3'd1;
    cyc(2);
    chk(td_n == 1 && dv_n == 1, "R9 inactive mode idles", {td_n, dv_n}, 3);
    cyc(50);
    chk(td_n == 1 && dv_n == 1, "R9 inactive stays idle", {td_n, dv_n}, 3);
    @(negedge clk); mode = 3'd0;
    cyc(1);
    chk(td_n == 0, "R9 td back in receive", td_n, 0);
    cyc(on_ms(1) * CPM - 3);
    chk(dv_n == 1, "R9 requalify from zero", dv_n, 1);
    cyc(6);
    chk(dv_n == 0, "R9 requalified", dv_n, 0);
    release_tone("R4");

    for (int it = 0; it < 24; it++) begin
      logic [3:0] c = 4'($urandom_range(0, 15));
      guard = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) begin
        int d = $urandom_range(2, on_ms(guard) * CPM - 6);
        drive(1, c);
        cyc(d);
        chk(dv_n == 1, "R11 random short tone", dv_n, 1);
        chk(td_n == 0, "R1 random td", td_n, 0);
        drive(0, c);
        cyc(off_ms(guard) * CPM + 5);
        chk(dv_n == 1, "R11 random stays idle", dv_n, 1);
      end else begin
        qualify(c, "R3");
        cyc($urandom_range(0, 40));
        chk(dv_n == 0 && code_o == c, "R8 random hold", code_o, c);
        release_tone("R4");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int guard_list[1];
endmodule